// File: doc/BRIEF.md
# Held-Request Register Window Bridge

This block lets a host reach the control registers of an external module through a small register window. On the host side, a single-cycle strobe carries a direction, an 8-bit offset and write data. The bridge turns that strobe into a request on the module side and holds it, with its qualifiers, until the module acknowledges. When the acknowledge arrives, the bridge returns a one-cycle completion strobe to the host. For reads, the data the module supplied on its acknowledge cycle comes back with that strobe.

Only one transfer is outstanding at a time. A host strobe that arrives while a transfer is still waiting is refused with a one-cycle busy pulse and is not queued. The external module can also raise an interrupt line. The bridge records it in a sticky status bit that the host clears by writing a one.

The reset input is asynchronous and active low. It is synchronised internally, so assertion takes effect at once and release takes effect on the third rising clock edge after the input goes high.

Top module: `regwin_bridge`

## Requirements
- R1: While reset is in effect, every output is 0: `mod_req`, `mod_rnw`, `mod_addr`, `mod_wdata`, `host_rdata`, `host_done`, `host_busy` and `host_irq`.
- R2: A host strobe sampled while no transfer is waiting raises `mod_req` in the next cycle. `mod_addr` then carries the `host_addr` from the strobe cycle.
- R3: While `mod_req` is high and `mod_ack` has not been sampled high, `mod_req`, `mod_rnw`, `mod_addr` and `mod_wdata` stay constant. `mod_wdata` equals the `host_wdata` from the strobe cycle.
- R4: `mod_req` is low in the cycle after an edge that samples `mod_ack` high while `mod_req` is high. While `mod_req` is low, `mod_rnw`, `mod_addr` and `mod_wdata` read 0.
- R5: `mod_rnw` is 1 for a read (`host_write`=0) and 0 for a write (`host_write`=1). It is valid in the first cycle that `mod_req` is high.
- R6: `host_done` is high for exactly the cycle after the acknowledge edge, for reads and for writes alike. On a read, `host_rdata` in that cycle holds the `mod_rdata` sampled at the acknowledge edge. On a write, `host_rdata` is left unchanged.
- R7: A host strobe sampled while `mod_req` is high gives a one-cycle `host_busy` pulse in the next cycle. It does not change the outstanding transfer.
- R8: Between two transfers, `mod_req` is low for at least one cycle.
- R9: `ext_irq` sampled high sets `host_irq` in the next cycle. `host_irq` then stays high until it is cleared.
- R10: `stat_we`=1 with `stat_wdata`=1 clears `host_irq`. `stat_we`=1 with `stat_wdata`=0 has no effect. When a set and a clear arrive in the same cycle, the set wins.
- R11: `mod_ack` while `mod_req` is low is ignored. It produces no `host_done` and leaves `host_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_strobe | input | 1 | Single-cycle access strobe from the host |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Window offset |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Data from the last completed read |
| host_done | output | 1 | One-cycle completion strobe |
| host_busy | output | 1 | One-cycle refusal pulse |
| stat_we | input | 1 | Interrupt status write strobe |
| stat_wdata | input | 1 | Write-one-to-clear value for the interrupt status |
| host_irq | output | 1 | Sticky interrupt status |
| mod_req | output | 1 | Held request to the external module |
| mod_rnw | output | 1 | Direction, 1 = read |
| mod_addr | output | ADDR_W | Access offset |
| mod_wdata | output | DATA_W | Write data |
| mod_rdata | input | DATA_W | Read data from the module |
| mod_ack | input | 1 | Transfer acknowledge from the module |
| ext_irq | input | 1 | Interrupt raise from the module |

## Verification
The bench runs a behavioural reference model that updates on the rising edge and then compares every output at the following falling edge. Each result therefore has a fixed due cycle, one edge after its cause:
- `mod_req` and its qualifiers appear one cycle after an accepted strobe.
- `host_done`, `host_rdata`, `host_busy` and `host_irq` appear one cycle after the edge that samples the acknowledge, the refused strobe, or the interrupt and clear inputs.

The responder model in the bench supports acknowledge latencies from zero to several cycles. Directed checks sample at exactly these cycles for three cases: a refused strobe, a strobe issued in the completion cycle, and a set and a clear arriving together.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Transfer sequencer state
  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_WAIT = 1'b1
  } xfer_state_e;

endpackage

// File: rtl/regwin_rstsync.sv
module regwin_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= {sync_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sync_q[LAST];

endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              mod_ack,
  output logic              mod_req,
  output logic              mod_rnw,
  output logic [ADDR_W-1:0] mod_addr,
  output logic [DATA_W-1:0] mod_wdata,
  output logic              cmd_rnw,
  output logic              complete,
  output logic              refuse
);

  xfer_state_e       st_q, st_d;
  logic              cmd_en;
  logic              rnw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // next state
  always_comb begin
    st_d     = st_q;
    cmd_en   = 1'b0;
    complete = 1'b0;
    refuse   = 1'b0;
    case (st_q)
      XS_IDLE: begin
        if (host_strobe) begin
          st_d   = XS_WAIT;
          cmd_en = 1'b1;
        end
      end
      XS_WAIT: begin
        refuse = host_strobe;
        if (mod_ack) begin
          complete = 1'b1;
          st_d     = XS_IDLE;
        end
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= XS_IDLE;
    else        st_q <= st_d;
  end

  // command hold registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnw_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cmd_en) begin
      rnw_q   <= ~host_write;
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
  end

  assign mod_req   = (st_q == XS_WAIT);
  assign mod_rnw   = mod_req & rnw_q;
  assign mod_addr  = mod_req ? addr_q  : '0;
  assign mod_wdata = mod_req ? wdata_q : '0;
  assign cmd_rnw   = rnw_q;

endmodule

// File: rtl/regwin_resp.sv
module regwin_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              complete,
  input  logic              refuse,
  input  logic              cmd_rnw,
  input  logic [DATA_W-1:0] mod_rdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              host_busy
);

  logic              cap_en;
  logic              done_d, busy_d;
  logic              done_q, busy_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    cap_en = complete & cmd_rnw;
    done_d = complete;
    busy_d = refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      done_q <= done_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= mod_rdata;
  end

  assign host_rdata = rdata_q;
  assign host_done  = done_q;
  assign host_busy  = busy_q;

endmodule

// File: rtl/regwin_irq.sv
module regwin_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_irq,
  input  logic stat_we,
  input  logic stat_wdata,
  output logic host_irq
);

  logic set_ev, clr_ev, pend_en, pend_d, pend_q;

  always_comb begin
    set_ev  = ext_irq;
    clr_ev  = stat_we & stat_wdata;
    pend_en = set_ev | clr_ev;
    pend_d  = set_ev;   // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign host_irq = pend_q;

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              host_busy,
  input  logic              stat_we,
  input  logic              stat_wdata,
  output logic              host_irq,
  output logic              mod_req,
  output logic              mod_rnw,
  output logic [ADDR_W-1:0] mod_addr,
  output logic [DATA_W-1:0] mod_wdata,
  input  logic [DATA_W-1:0] mod_rdata,
  input  logic              mod_ack,
  input  logic              ext_irq
);

  logic rst_int_n;
  logic cmd_rnw, complete, refuse;

  regwin_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  regwin_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .host_strobe (host_strobe),
    .host_write  (host_write),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .mod_ack     (mod_ack),
    .mod_req     (mod_req),
    .mod_rnw     (mod_rnw),
    .mod_addr    (mod_addr),
    .mod_wdata   (mod_wdata),
    .cmd_rnw     (cmd_rnw),
    .complete    (complete),
    .refuse      (refuse)
  );

  regwin_resp #(.DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .complete   (complete),
    .refuse     (refuse),
    .cmd_rnw    (cmd_rnw),
    .mod_rdata  (mod_rdata),
    .host_rdata (host_rdata),
    .host_done  (host_done),
    .host_busy  (host_busy)
  );

  regwin_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ext_irq    (ext_irq),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .host_irq   (host_irq)
  );

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_strobe,
  input logic              stat_we,
  input logic              stat_wdata,
  input logic              ext_irq,
  input logic              mod_req,
  input logic              mod_ack,
  input logic              mod_rnw,
  input logic [ADDR_W-1:0] mod_addr,
  input logic [DATA_W-1:0] mod_wdata,
  input logic              host_done,
  input logic              host_busy,
  input logic              host_irq
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!mod_req && !mod_rnw && mod_addr == '0 && mod_wdata == '0 &&
                !host_done && !host_busy && !host_irq));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_req && !mod_ack) |=> (mod_req && $stable(mod_rnw) && $stable(mod_addr) && $stable(mod_wdata)));

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_req && mod_ack) |=> !mod_req);

  // R6
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_req && mod_ack) |=> host_done);

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> $past(mod_req && mod_ack));

  // R7
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> $past(mod_req && host_strobe));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |=> host_irq);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !(stat_we && stat_wdata)) |=> host_irq);

endmodule

bind regwin_bridge regwin_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .host_strobe (host_strobe),
  .stat_we     (stat_we),
  .stat_wdata  (stat_wdata),
  .ext_irq     (ext_irq),
  .mod_req     (mod_req),
  .mod_ack     (mod_ack),
  .mod_rnw     (mod_rnw),
  .mod_addr    (mod_addr),
  .mod_wdata   (mod_wdata),
  .host_done   (host_done),
  .host_busy   (host_busy),
  .host_irq    (host_irq)
);

// File: tb/tb_regwin_bridge.sv
module tb_regwin_bridge;

  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk, rst_n;
  logic          host_strobe, host_write;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic          host_done, host_busy;
  logic          stat_we, stat_wdata, host_irq;
  logic          mod_req, mod_rnw, mod_ack, ext_irq;
  logic [AW-1:0] mod_addr;
  logic [DW-1:0] mod_wdata, mod_rdata;

  regwin_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .host_strobe(host_strobe), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .host_busy(host_busy), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .host_irq(host_irq), .mod_req(mod_req),
    .mod_rnw(mod_rnw), .mod_addr(mod_addr), .mod_wdata(mod_wdata),
    .mod_rdata(mod_rdata), .mod_ack(mod_ack), .ext_irq(ext_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  reported = 0;
  bit  cmp_on = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
  endtask

  function automatic logic [DW-1:0] rpat(input logic [AW-1:0] a);
    return {a, 8'h5A, ~a, a ^ 8'h3C};
  endfunction

  // external module responder
  int            lat;
  int            rcnt;
  logic          resp_ack, force_ack;
  logic [DW-1:0] resp_rdata;
  assign mod_ack   = resp_ack | force_ack;
  assign mod_rdata = resp_rdata;

  always @(negedge clk) begin
    if (!mod_req) begin
      rcnt = 0;
      resp_ack = 1'b0;
    end else if (resp_ack) begin
      resp_ack = 1'b0;
    end else if (rcnt >= lat) begin
      resp_ack = 1'b1;
      resp_rdata = rpat(mod_addr);
    end else begin
      rcnt++;
    end
  end

  // behavioural reference model
  bit            m_rs1, m_rs2, m_act;
  bit            m_req, m_rnw, m_done, m_busy, m_irq;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0;
      m_req = 0; m_rnw = 0; m_done = 0; m_busy = 0; m_irq = 0;
      m_addr = '0; m_wdata = '0; m_rdata = '0;
    end else begin
      m_act = m_rs2;
      m_rs2 = m_rs1;
      m_rs1 = 1;
      if (!m_act) begin
        m_req = 0; m_rnw = 0; m_done = 0; m_busy = 0; m_irq = 0;
        m_addr = '0; m_wdata = '0; m_rdata = '0;
      end else begin
        m_done = 0;
        m_busy = 0;
        if (m_req) begin
          if (host_strobe) m_busy = 1;
          if (mod_ack) begin
            m_req  = 0;
            m_done = 1;
            if (m_rnw) m_rdata = mod_rdata;
          end
        end else if (host_strobe) begin
          m_req   = 1;
          m_rnw   = !host_write;
          m_addr  = host_addr;
          m_wdata = host_wdata;
        end
        if (ext_irq) m_irq = 1;
        else if (stat_we && stat_wdata) m_irq = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 mod_req",     32'(mod_req),   32'(m_req));
      chk("R5 mod_rnw",     32'(mod_rnw),   32'(m_req & m_rnw));
      chk("R2 mod_addr",    32'(mod_addr),  m_req ? 32'(m_addr) : 32'd0);
      chk("R3 mod_wdata",   mod_wdata,      m_req ? m_wdata : 32'd0);
      chk("R6 host_rdata",  host_rdata,     m_rdata);
      chk("R6 host_done",   32'(host_done), 32'(m_done));
      chk("R7 host_busy",   32'(host_busy), 32'(m_busy));
      chk("R9 host_irq",    32'(host_irq),  32'(m_irq));
    end
  end

  // R8: request must be low in the cycle after an accepted acknowledge
  logic ack_edge;
  always @(posedge clk) ack_edge <= mod_req && mod_ack;
  always @(negedge clk) begin
    if (cmp_on && ack_edge === 1'b1) chk("R8 gap after ack", 32'(mod_req), 32'd0);
  end

  task automatic do_xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input int l);
    lat = l;
    @(negedge clk);
    host_strobe = 1; host_write = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_strobe = 0;
    chk("R5 direction on first req cycle", 32'(mod_rnw), 32'(!wr));
    for (int i = 0; i < 40; i++) begin
      if (host_done) break;
      @(negedge clk);
    end
    chk("R6 done seen", 32'(host_done), 32'd1);
    if (!wr) chk("R6 read data", host_rdata, rpat(a));
  endtask

  initial begin
    host_strobe = 0; host_write = 0; host_addr = '0; host_wdata = '0;
    stat_we = 0; stat_wdata = 0; ext_irq = 0;
    force_ack = 0; resp_ack = 0; resp_rdata = '0; lat = 0; rcnt = 0;
    rst_n = 1;
    #2 rst_n = 0;
    #1 cmp_on = 1;

    // R1: stimulus during reset has no effect
    @(negedge clk);
    host_strobe = 1; host_addr = 8'h77; ext_irq = 1;
    repeat (2) @(negedge clk);
    chk("R1 mod_req in reset", 32'(mod_req), 32'd0);
    chk("R1 host_irq in reset", 32'(host_irq), 32'd0);
    chk("R1 mod_addr in reset", 32'(mod_addr), 32'd0);
    host_strobe = 0; ext_irq = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);

    // basic transfers with various latencies
    do_xfer(1, 8'h12, 32'hDEAD_BEEF, 0);
    do_xfer(0, 8'hA5, 32'h0, 2);
    do_xfer(0, 8'hFF, 32'h1111_2222, 5);
    do_xfer(1, 8'h00, 32'hCAFE_0001, 3);
    chk("R6 write leaves rdata", host_rdata, rpat(8'hFF));

    // R7: refused strobe while waiting
    lat = 4;
    @(negedge clk);
    host_strobe = 1; host_write = 1; host_addr = 8'h33; host_wdata = 32'h3333_3333;
    @(negedge clk);
    host_write = 0; host_addr = 8'h44; host_wdata = 32'h4444_4444;
    @(negedge clk);
    host_strobe = 0;
    chk("R7 busy pulse", 32'(host_busy), 32'd1);
    chk("R7 addr kept", 32'(mod_addr), 32'h33);
    chk("R3 wdata kept", mod_wdata, 32'h3333_3333);
    chk("R5 rnw kept", 32'(mod_rnw), 32'd0);
    @(negedge clk);
    chk("R7 busy single cycle", 32'(host_busy), 32'd0);
    for (int i = 0; i < 20; i++) begin
      if (host_done) break;
      @(negedge clk);
    end
    // R8: strobe issued in the completion cycle, request low that cycle
    chk("R8 req low in done cycle", 32'(mod_req), 32'd0);
    lat = 1;
    host_strobe = 1; host_write = 0; host_addr = 8'h5C;
    @(negedge clk);
    host_strobe = 0;
    chk("R2 back-to-back accepted", 32'(mod_addr), 32'h5C);
    for (int i = 0; i < 20; i++) begin
      if (host_done) break;
      @(negedge clk);
    end
    chk("R6 back-to-back read", host_rdata, rpat(8'h5C));

    // R9 / R10: interrupt status
    @(negedge clk); ext_irq = 1;
    @(negedge clk); ext_irq = 0;
    chk("R9 irq set", 32'(host_irq), 32'd1);
    stat_we = 1; stat_wdata = 0;
    @(negedge clk); stat_we = 0;
    chk("R10 write zero keeps irq", 32'(host_irq), 32'd1);
    stat_we = 1; stat_wdata = 1; ext_irq = 1;
    @(negedge clk); stat_we = 0; ext_irq = 0;
    chk("R10 set wins over clear", 32'(host_irq), 32'd1);
    stat_we = 1; stat_wdata = 1;
    @(negedge clk); stat_we = 0; stat_wdata = 0;
    chk("R10 clear", 32'(host_irq), 32'd0);

    // R11: stray acknowledge while idle
    @(negedge clk); force_ack = 1;
    @(negedge clk); force_ack = 0;
    chk("R11 no done on stray ack", 32'(host_done), 32'd0);
    chk("R11 rdata unchanged", host_rdata, rpat(8'h5C));
    chk("R11 no request", 32'(mod_req), 32'd0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule